// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block runs register accesses to an Ethernet PHY over the two-wire management link. The host presents one command: read or write, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. It then raises a one-cycle start strobe. The block derives the management clock from the system clock and sends the complete serial frame. On a read, it hands the data line to the PHY and collects the reply. When the frame is over, it reports with a one-cycle done pulse.

The data line is presented as three signals: an output value, an output enable and an input. The pad-level tri-state buffer and pull-up sit outside the block. A read checks that the PHY pulls the line low during the second turnaround slot. If the line is high there, the read is flagged as failed and its data is forced to zero. Every change of line ownership happens while the management clock is steady low.

Top module: `mgmt_frame_master`

## Requirements
- R1: After reset, mdc is low, mdio_oe is 1, mdio_o is 1, done is 0, rd_data is 0 and rd_error is 0.
- R2: Each frame opens with 32 mdc cycles during which mdio_oe is 1 and mdio_o is 1.
- R3: After the preamble the block sends the following fields, each MSB first and one bit per mdc rising edge: start code 01, then opcode (10 for a read, 01 for a write), then the PHY address, then the register address. Every frame lasts exactly 64 mdc cycles.
- R4: The mdc high phase and the mdc low phase each last HALF_DIV system clocks. mdio_o never changes while mdc stays high, so it changes only on or after a falling edge.
- R5: On a write, the register address is followed by the turnaround pattern 10 and then the 16 data bits, MSB first. mdio_oe stays 1 for all 64 slots.
- R6: On a read, mdio_oe stays 1 through the register address (slot 45) and is 0 for slots 46 to 63. It returns to 1 after the last data slot. Neither change of mdio_oe occurs in a cycle where mdc changes.
- R7: On a read, mdio_i is sampled in the last system clock of the low phase of slot 47, the second turnaround slot. A high level sets rd_error. A write leaves rd_error at 0.
- R8: On a read, mdio_i is sampled in the last low-phase clock of slots 48 to 63 and assembled MSB first into rd_data. When rd_error is set, rd_data is 0 whatever the line carried.
- R9: done is high for exactly one system clock per accepted command, after the last slot. rd_data and rd_error are valid in that cycle and hold their values until the next accepted start.
- R10: A start strobe arriving while a frame is in progress is ignored: the running frame is unchanged and no extra frame or done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle request to begin a frame |
| cmd_read | input | 1 | 1 selects read, 0 selects write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read result, 0 on a failed read |
| rd_error | output | 1 | Read saw no PHY response in turnaround |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | 1 when the block drives the data line |
| mdio_i | input | 1 | Data line level as seen at the pad |

## Verification
A PHY model in the bench records every bit at the mdc rising edges and answers reads. The tests sweep all 32 PHY addresses with spread register addresses, which exposes field-order or bit-order mistakes in the header. Writes use walking-one data, which separates each data position and the turnaround pattern. Reads with a responding PHY return address-derived data. Reads from an absent PHY put a non-zero pattern on the line, so a block that ignores the error flag and keeps sampling is caught. A start strobe sent in the middle of a write shows whether a busy frame can be disturbed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_AW    = 5;
    localparam int REG_AW    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int ST_LEN    = 2;
    localparam int OP_LEN    = 2;
    localparam int TA_LEN    = 2;

    // first slot after the register address field
    localparam int HDR_END    = PRE_LEN + ST_LEN + OP_LEN + PHY_AW + REG_AW;
    localparam int TA_SAMPLE  = HDR_END + 1;
    localparam int DATA_FIRST = HDR_END + TA_LEN;
    localparam int FRAME_LEN  = DATA_FIRST + DATA_W;
    localparam int SLOT_W     = $clog2(FRAME_LEN);

    localparam logic [ST_LEN-1:0] CODE_START = 2'b01;
    localparam logic [OP_LEN-1:0] OP_RD      = 2'b10;
    localparam logic [OP_LEN-1:0] OP_WR      = 2'b01;
    localparam logic [TA_LEN-1:0] TA_WR      = 2'b10;

    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [FRAME_LEN-1:0] frame_t;

    typedef struct packed {
        logic              rd;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mgmt_cmd_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_FINISH
    } seq_state_e;

    // Whole frame as one vector, first bit on the wire in the MSB.
    function automatic frame_t build_frame(input mgmt_cmd_t c);
        logic [OP_LEN-1:0]        op;
        logic [TA_LEN+DATA_W-1:0] tail;
        op   = c.rd ? OP_RD : OP_WR;
        tail = c.rd ? '1 : {TA_WR, c.wdata};
        return {{PRE_LEN{1'b1}}, CODE_START, op, c.phy, c.regad, tail};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic first_low,
    output logic smp_stb,
    output logic end_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          ph_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc       = ph_q;
    assign first_low = run && !ph_q && (cnt_q == '0);
    assign smp_stb   = run && !ph_q && (cnt_q == CNT_LAST);
    assign end_stb   = run &&  ph_q && (cnt_q == CNT_LAST);

    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  mgmt_cmd_t cmd,
    input  logic      first_low,
    input  logic      end_stb,
    output logic      run,
    output logic      accept,
    output slot_t     slot,
    output logic      is_rd,
    output logic      mdo,
    output logic      oe,
    output logic      done
);
    seq_state_e st_q;
    slot_t      slot_q;
    frame_t     sh_q;
    logic       rd_q;
    logic       oe_q;
    logic       done_q;

    assign accept = (st_q == SEQ_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            slot_q <= '0;
            sh_q   <= '1;
            rd_q   <= 1'b0;
            oe_q   <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                SEQ_IDLE: begin
                    if (start) begin
                        st_q   <= SEQ_RUN;
                        slot_q <= '0;
                        sh_q   <= build_frame(cmd);
                        rd_q   <= cmd.rd;
                    end
                end
                SEQ_RUN: begin
                    // hand the line over one clock into the low phase
                    if (rd_q && first_low && slot_q == slot_t'(HDR_END))
                        oe_q <= 1'b0;
                    if (end_stb) begin
                        if (slot_q == slot_t'(FRAME_LEN - 1)) begin
                            st_q <= SEQ_FINISH;
                            sh_q <= '1;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                            sh_q   <= {sh_q[FRAME_LEN-2:0], 1'b1};
                        end
                    end
                end
                SEQ_FINISH: begin
                    oe_q   <= 1'b1;
                    done_q <= 1'b1;
                    st_q   <= SEQ_IDLE;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign run   = (st_q == SEQ_RUN);
    assign slot  = slot_q;
    assign is_rd = rd_q;
    assign mdo   = sh_q[FRAME_LEN-1];
    assign oe    = oe_q;
    assign done  = done_q;

    // R2
    preamble_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_RUN && slot_q < slot_t'(PRE_LEN)) |-> (mdo && oe_q));

    // R5
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != SEQ_IDLE && !rd_q) |-> oe_q);

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_RUN && rd_q && slot_q > slot_t'(HDR_END)) |-> !oe_q);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != SEQ_IDLE) |=> $stable(rd_q));

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              smp_stb,
    input  slot_t             slot,
    input  logic              is_rd,
    input  logic              mdi,
    output logic [DATA_W-1:0] rd_data,
    output logic              err
);
    logic [DATA_W-1:0] data_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            data_q <= '0;
            err_q  <= 1'b0;
        end else if (smp_stb && is_rd) begin
            if (slot == slot_t'(TA_SAMPLE))
                err_q <= mdi;
            else if (slot >= slot_t'(DATA_FIRST) && !err_q)
                data_q <= {data_q[DATA_W-2:0], mdi};
        end
    end

    assign rd_data = data_q;
    assign err     = err_q;

    // R8
    zero_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (data_q == '0));

    // R7
    wr_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        !is_rd |-> !err_q);

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_read,
    input  logic [PHY_AW-1:0] cmd_phy,
    input  logic [REG_AW-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_error,
    output logic              done,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mgmt_cmd_t cmd;
    logic      run, accept, is_rd;
    logic      first_low, smp_stb, end_stb;
    slot_t     slot;

    assign cmd = '{rd: cmd_read, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .mdc       (mdc),
        .first_low (first_low),
        .smp_stb   (smp_stb),
        .end_stb   (end_stb)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_start),
        .cmd       (cmd),
        .first_low (first_low),
        .end_stb   (end_stb),
        .run       (run),
        .accept    (accept),
        .slot      (slot),
        .is_rd     (is_rd),
        .mdo       (mdio_o),
        .oe        (mdio_oe),
        .done      (done)
    );

    mdio_rx_capture u_rx (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .smp_stb (smp_stb),
        .slot    (slot),
        .is_rd   (is_rd),
        .mdi     (mdio_i),
        .rd_data (rd_data),
        .err     (rd_error)
    );

    // R6
    oe_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe != $past(mdio_oe)) |-> (mdc == $past(mdc)));

    // R4
    mdo_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> (mdio_o == $past(mdio_o)));

endmodule

// File: tb/sim_mgmt_frame_master.sv
module sim_mgmt_frame_master;
    import mdio_pkg::*;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_error, done, mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    always #5 clk = ~clk;

    mgmt_frame_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .rd_data(rd_data), .rd_error(rd_error), .done(done), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0, n_bad = 0;
    int rise_cnt = 0, base = 1000000, done_cnt = 0;
    int edge_viol = 0, mdo_viol = 0, len_viol = 0, hi_len = 0, mon_idx;
    logic p_mdc = 1'b0, p_oe = 1'b1, p_mdo = 1'b1;
    logic bit_v [64];
    logic oe_v  [64];
    logic        ta_lvl = 1'b0;
    logic [15:0] phy_data = '0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // PHY model and line monitor, all on the falling system clock edge
    initial begin
        mdio_i = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (mdc && !p_mdc) begin
                    mon_idx = rise_cnt - base;
                    if (mon_idx >= 0 && mon_idx < 64) begin
                        bit_v[mon_idx] = mdio_o;
                        oe_v[mon_idx]  = mdio_oe;
                    end
                    rise_cnt++;
                end
                if (mdc) hi_len++;
                else if (p_mdc) begin
                    if (hi_len != HALF) len_viol++;
                    hi_len = 0;
                end
                if (mdio_oe != p_oe && mdc != p_mdc) edge_viol++;
                if (mdc && p_mdc && mdio_o != p_mdo) mdo_viol++;
                if (done) done_cnt++;
                mon_idx = rise_cnt - base;
                if (mon_idx == TA_SAMPLE) mdio_i = ta_lvl;
                else if (mon_idx >= DATA_FIRST && mon_idx < FRAME_LEN)
                    mdio_i = phy_data[FRAME_LEN-1-mon_idx];
                else mdio_i = 1'b1;
            end
            p_mdc = mdc; p_oe = mdio_oe; p_mdo = mdio_o;
        end
    end

    task automatic run_txn(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] wd, input logic ta, input logic [15:0] pd,
                           input logic intrude);
        logic [63:0] cap, ocap, exp_o;
        logic [13:0] hdr;
        logic [15:0] got_d, exp_d;
        logic        got_e;
        int d0, waited, r_snap, d_snap;
        ta_lvl = ta; phy_data = pd;
        for (int k = 0; k < 64; k++) begin bit_v[k] = 1'b0; oe_v[k] = 1'b0; end
        @(negedge clk);
        base = rise_cnt; d0 = done_cnt;
        cmd_read = rd; cmd_phy = phy; cmd_reg = ra; cmd_wdata = wd; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        waited = 0;
        if (intrude) begin
            repeat (30) @(negedge clk);
            cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~ra; cmd_wdata = ~wd; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
        end
        while (!done && waited < 4000) begin @(negedge clk); waited++; end
        check("R9 done seen", 64'(done), 64'd1);
        got_d = rd_data; got_e = rd_error;
        @(negedge clk);
        check("R9 done one cycle", 64'(done), 64'd0);
        check("R9 one done per command", 64'(done_cnt - d0), 64'd1);
        check("R9 rd_data held", 64'(rd_data), 64'(got_d));
        for (int k = 0; k < 64; k++) begin
            cap[63-k]  = bit_v[k];
            ocap[63-k] = oe_v[k];
        end
        hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
        check("R3 mdc cycles per frame", 64'(rise_cnt - base), 64'd64);
        check("R2 preamble ones", 64'(cap[63:32]), 64'hFFFF_FFFF);
        check("R3 header fields", 64'(cap[31:18]), 64'(hdr));
        if (rd) begin
            exp_o = {{46{1'b1}}, {18{1'b0}}};
            check("R6 line ownership on read", ocap, exp_o);
            exp_d = ta ? 16'h0000 : pd;
            check("R8 read data", 64'(got_d), 64'(exp_d));
            check("R7 turnaround error", 64'(got_e), 64'(ta));
        end else begin
            check("R5 write tail", 64'(cap[17:0]), 64'({2'b10, wd}));
            check("R5 line driven on write", ocap, 64'hFFFF_FFFF_FFFF_FFFF);
            check("R7 no error on write", 64'(got_e), 64'd0);
        end
        if (intrude) begin
            r_snap = rise_cnt; d_snap = done_cnt;
            repeat (300) @(negedge clk);
            check("R10 no extra frame", 64'(rise_cnt - r_snap), 64'd0);
            check("R10 no extra done", 64'(done_cnt - d_snap), 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mdc", 64'(mdc), 64'd0);
        check("R1 mdio_oe", 64'(mdio_oe), 64'd1);
        check("R1 mdio_o", 64'(mdio_o), 64'd1);
        check("R1 done", 64'(done), 64'd0);
        check("R1 rd_data", 64'(rd_data), 64'd0);
        check("R1 rd_error", 64'(rd_error), 64'd0);
        for (int p = 0; p < 32; p++)
            run_txn(1'b0, 5'(p), 5'((p * 7) % 32), 16'h8001 ^ 16'(p * 16'h0911), 1'b0, 16'h0, 1'b0);
        for (int b = 0; b < 16; b++)
            run_txn(1'b0, 5'(b + 3), 5'(b), 16'(1) << b, 1'b0, 16'h0, 1'b0);
        for (int p = 0; p < 32; p++)
            run_txn(1'b1, 5'(p), 5'(p ^ 5), 16'h0000, 1'b0, 16'hF00F ^ 16'(p * 16'h1357), 1'b0);
        // R7 R8 absent PHY with busy line
        run_txn(1'b1, 5'd9,  5'd2,  16'h0, 1'b1, 16'hA5A5, 1'b0);
        run_txn(1'b1, 5'd31, 5'd31, 16'h0, 1'b1, 16'hFFFF, 1'b0);
        run_txn(1'b1, 5'd0,  5'd1,  16'h0, 1'b0, 16'h8001, 1'b0);
        run_txn(1'b1, 5'd17, 5'd0,  16'h0, 1'b1, 16'h1234, 1'b0);
        // R10 start strobe during a running write
        run_txn(1'b0, 5'd21, 5'd13, 16'hC3E1, 1'b0, 16'h0, 1'b1);
        run_txn(1'b1, 5'd6,  5'd27, 16'h0, 1'b0, 16'h5AA5, 1'b1);
        check("R4 mdc high phase length", 64'(len_viol), 64'd0);
        check("R4 mdio_o steady while mdc high", 64'(mdo_viol), 64'd0);
        check("R6 no mdc edge at ownership change", 64'(edge_viol), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule